// File: doc/BRIEF.md
# Two-Frequency FSK Tag Waveform Generator

This block produces the serial load-modulation waveform of a low-frequency proximity tag that signals with frequency-shift keying. Each output sample is a coil drive bit: 1 leaves the coil open, 0 shorts it. The waveform is built from two subcarrier groups. A fast group repeats an 8-sample period six times (48 samples). A slow group repeats a 10-sample period five times (50 samples). One sample is emitted on each strobe derived from the field clock.

After an accepted start, the block latches a 44-bit identifier. It then sends frames back to back without any gap. Each frame holds a start-of-frame marker made of groups that break the Manchester rule, then the identifier, most significant bit first, as pairs of groups. Before every fourth data bit an extra fast group is inserted. The frames repeat until stop is raised. While stopped, the coil is held open.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: After reset, `coilOpen` is 1, `busy` is 0 and `frameDone` is 0.
- R2: A fast group is the sample period 1,1,0,0,0,0,0,0 emitted six times (48 samples, 12 of them 1). A slow group is the period 1,1,1,0,0,0,0,0,0,0 emitted five times (50 samples, 15 of them 1). A sample value of 1 means the coil is open.
- R3: Every frame opens with eight groups in the order fast, fast, fast, slow, slow, slow, fast, slow.
- R4: Identifier bits go out from bit 43 down to bit 0. A 1 is a slow group followed by a fast group. A 0 is a fast group followed by a slow group.
- R5: An extra fast group comes just before each data bit whose index modulo 4 equals 3.
- R6: A frame is 5232 samples long. The next frame starts at its marker on the very next strobe. `frameDone` is high for exactly one cycle: the cycle after the clock edge that emitted the last sample of a frame.
- R7: A start request while idle is refused if any of `idIn[47:44]` is set. In that case `busy` stays 0 and the coil stays open.
- R8: `coilOpen` changes only on a clock edge where `sampleStb` is high and the block is busy. Strobes while idle have no effect.
- R9: When `stopReq` is high while busy, the next edge clears `busy` and opens the coil. Stop wins over a strobe in the same cycle.
- R10: A start request while busy is ignored. The frame in progress and the latched identifier are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Latches `idIn` and begins framing when idle |
| stopReq | input | 1 | Ends framing and opens the coil |
| sampleStb | input | 1 | One-cycle strobe per field-clock sample |
| idIn | input | 48 | Identifier; only bits 43..0 may be set |
| coilOpen | output | 1 | Coil drive: 1 open, 0 shorted |
| busy | output | 1 | Framing in progress |
| frameDone | output | 1 | One-cycle pulse after each full frame |

## Verification
The bench builds the block with its default values: a 44-bit identifier on a 48-bit input, groups of 8×6 and 10×5 samples, and a filler every four bits. With these values, each frame is 5232 samples long, so several complete frames fit within the run. The run covers a strobe on every cycle and a strobe on every third cycle. It also reaches the refused identifier, a stop that coincides with a strobe, a start while busy, and the seam where one frame runs directly into the next.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

  // Strobes from sequencing control to the sample datapath
  typedef struct packed {
    logic clear;    // return counters to group start and open the coil
    logic step;     // emit one sample
    logic grpSlow;  // current group uses the slow subcarrier
  } dpCtrl_t;

  typedef enum logic [1:0] {
    SEG_SOF    = 2'd0,
    SEG_FILL   = 2'd1,
    SEG_HALF_A = 2'd2,
    SEG_HALF_B = 2'd3
  } seg_e;

endpackage

// File: rtl/fsk_tag_ctrl.sv
module fsk_tag_ctrl
  import fsk_tag_pkg::*;
#(
  parameter int ID_BITS    = 44,
  parameter int ID_IN_W    = 48,
  parameter int FILL_EVERY = 4,
  parameter int SOF_GROUPS = 8,
  parameter logic [SOF_GROUPS-1:0] SOF_SLOW_MAP = 8'b1011_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic               sampleStb,
  input  logic [ID_IN_W-1:0] idIn,
  input  logic               grpLast,
  output dpCtrl_t            dpCtrl,
  output logic               busy,
  output logic               frameDone
);

  localparam int BW = $clog2(ID_BITS);
  localparam int SW = $clog2(SOF_GROUPS);
  localparam logic [BW-1:0] TOP_IDX = BW'(ID_BITS - 1);
  localparam logic [SW-1:0] LAST_SOF = SW'(SOF_GROUPS - 1);

  logic [ID_BITS-1:0] idReg;
  logic [BW-1:0]      bitIdx;
  logic [SW-1:0]      sofIdx;
  seg_e               seg;
  logic               busyQ;
  logic               doneQ;
  logic               idOk;
  logic               accept;
  logic               halt;
  logic               step;
  logic               curBit;
  logic               grpSlow;

  // Identifier range check: only present when the input is wider than the ID
  generate
    if (ID_IN_W > ID_BITS) begin : g_range
      assign idOk = (idIn[ID_IN_W-1:ID_BITS] == '0);
    end else begin : g_norange
      assign idOk = 1'b1;
    end
  endgenerate

  function automatic logic fillerBefore(input logic [BW-1:0] idx);
    return (int'(idx) % FILL_EVERY) == (FILL_EVERY - 1);
  endfunction

  assign accept = !busyQ && startReq && idOk;
  assign halt   = busyQ && stopReq;
  assign step   = busyQ && sampleStb && !stopReq;
  assign curBit = idReg[bitIdx];

  always_comb begin
    unique case (seg)
      SEG_SOF:    grpSlow = SOF_SLOW_MAP[sofIdx];
      SEG_FILL:   grpSlow = 1'b0;
      SEG_HALF_A: grpSlow = curBit;
      SEG_HALF_B: grpSlow = !curBit;
      default:    grpSlow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      seg    <= SEG_SOF;
      sofIdx <= '0;
      bitIdx <= TOP_IDX;
      idReg  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ  <= 1'b1;
        idReg  <= idIn[ID_BITS-1:0];
        seg    <= SEG_SOF;
        sofIdx <= '0;
        bitIdx <= TOP_IDX;
      end else if (halt) begin
        busyQ <= 1'b0;
      end else if (grpLast) begin
        unique case (seg)
          SEG_SOF: begin
            if (sofIdx == LAST_SOF) begin
              sofIdx <= '0;
              seg    <= fillerBefore(TOP_IDX) ? SEG_FILL : SEG_HALF_A;
            end else begin
              sofIdx <= sofIdx + 1'b1;
            end
          end
          SEG_FILL:   seg <= SEG_HALF_A;
          SEG_HALF_A: seg <= SEG_HALF_B;
          SEG_HALF_B: begin
            if (bitIdx == '0) begin
              seg    <= SEG_SOF;
              bitIdx <= TOP_IDX;
              doneQ  <= 1'b1;
            end else begin
              bitIdx <= bitIdx - 1'b1;
              seg    <= fillerBefore(bitIdx - 1'b1) ? SEG_FILL : SEG_HALF_A;
            end
          end
          default: seg <= SEG_SOF;
        endcase
      end
    end
  end

  assign dpCtrl.clear   = accept || halt;
  assign dpCtrl.step    = step;
  assign dpCtrl.grpSlow = grpSlow;
  assign busy           = busyQ;
  assign frameDone      = doneQ;

endmodule

// File: rtl/fsk_tag_datapath.sv
module fsk_tag_datapath
  import fsk_tag_pkg::*;
#(
  parameter int FAST_DIV  = 8,
  parameter int FAST_HIGH = 2,
  parameter int FAST_REP  = 6,
  parameter int SLOW_DIV  = 10,
  parameter int SLOW_HIGH = 3,
  parameter int SLOW_REP  = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  dpCtrl_t dpCtrl,
  output logic    grpLast,
  output logic    coilOpen
);

  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int MAX_REP = (FAST_REP > SLOW_REP) ? FAST_REP : SLOW_REP;
  localparam int PW = $clog2(MAX_DIV);
  localparam int RW = $clog2(MAX_REP);
  localparam logic [PW-1:0] FAST_PLAST = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] SLOW_PLAST = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_HI    = PW'(FAST_HIGH);
  localparam logic [PW-1:0] SLOW_HI    = PW'(SLOW_HIGH);
  localparam logic [RW-1:0] FAST_RLAST = RW'(FAST_REP - 1);
  localparam logic [RW-1:0] SLOW_RLAST = RW'(SLOW_REP - 1);

  logic [PW-1:0] phase;
  logic [RW-1:0] rep;
  logic [PW-1:0] periodLast;
  logic [PW-1:0] highLen;
  logic [RW-1:0] repLastVal;
  logic          sampleBit;
  logic          periodEnd;
  logic          repEnd;
  logic          coilQ;

  assign periodLast = dpCtrl.grpSlow ? SLOW_PLAST : FAST_PLAST;
  assign highLen    = dpCtrl.grpSlow ? SLOW_HI    : FAST_HI;
  assign repLastVal = dpCtrl.grpSlow ? SLOW_RLAST : FAST_RLAST;

  assign sampleBit = (phase < highLen);
  assign periodEnd = (phase == periodLast);
  assign repEnd    = (rep == repLastVal);
  assign grpLast   = dpCtrl.step && periodEnd && repEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      rep   <= '0;
      coilQ <= 1'b1;
    end else if (dpCtrl.clear) begin
      phase <= '0;
      rep   <= '0;
      coilQ <= 1'b1;
    end else if (dpCtrl.step) begin
      coilQ <= sampleBit;
      if (periodEnd) begin
        phase <= '0;
        rep   <= repEnd ? '0 : rep + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign coilOpen = coilQ;

endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
  import fsk_tag_pkg::*;
#(
  parameter int ID_BITS    = 44,
  parameter int ID_IN_W    = 48,
  parameter int FILL_EVERY = 4,
  parameter int FAST_DIV   = 8,
  parameter int FAST_HIGH  = 2,
  parameter int FAST_REP   = 6,
  parameter int SLOW_DIV   = 10,
  parameter int SLOW_HIGH  = 3,
  parameter int SLOW_REP   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic               sampleStb,
  input  logic [ID_IN_W-1:0] idIn,
  output logic               coilOpen,
  output logic               busy,
  output logic               frameDone
);

  dpCtrl_t dpCtrl;
  logic    grpLast;

  fsk_tag_ctrl #(
    .ID_BITS   (ID_BITS),
    .ID_IN_W   (ID_IN_W),
    .FILL_EVERY(FILL_EVERY)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .stopReq  (stopReq),
    .sampleStb(sampleStb),
    .idIn     (idIn),
    .grpLast  (grpLast),
    .dpCtrl   (dpCtrl),
    .busy     (busy),
    .frameDone(frameDone)
  );

  fsk_tag_datapath #(
    .FAST_DIV (FAST_DIV),
    .FAST_HIGH(FAST_HIGH),
    .FAST_REP (FAST_REP),
    .SLOW_DIV (SLOW_DIV),
    .SLOW_HIGH(SLOW_HIGH),
    .SLOW_REP (SLOW_REP)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .dpCtrl  (dpCtrl),
    .grpLast (grpLast),
    .coilOpen(coilOpen)
  );

endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int ID_BITS = 44,
  parameter int ID_IN_W = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               startReq,
  input logic               stopReq,
  input logic               sampleStb,
  input logic [ID_IN_W-1:0] idIn,
  input logic               coilOpen,
  input logic               busy,
  input logic               frameDone
);

  // R1, R9: an idle generator always leaves the coil open
  assert_idle_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> coilOpen);

  // R6: completion pulse lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  // R6: completion only reported while framing
  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> busy);

  // R8: without a strobe the coil level holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleStb && !stopReq) |=> $stable(coilOpen));

  // R7: identifiers with bits above the allowed width are refused
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && ((idIn >> ID_BITS) != '0)) |=> !busy);

  // R9: stop ends framing and opens the coil on the next edge
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stopReq) |=> (!busy && coilOpen));

  // R10: a start while busy never drops busy by itself
  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startReq && !stopReq) |=> busy);

endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
  .ID_BITS(ID_BITS),
  .ID_IN_W(ID_IN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .startReq (startReq),
  .stopReq  (stopReq),
  .sampleStb(sampleStb),
  .idIn     (idIn),
  .coilOpen (coilOpen),
  .busy     (busy),
  .frameDone(frameDone)
);

// File: tb/fsk_tag_wavegen_test.sv
`timescale 1ns/1ps
module fsk_tag_wavegen_test;

  localparam int FRAME_LEN = 5232;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startReq = 1'b0;
  logic        stopReq = 1'b0;
  logic        sampleStb = 1'b0;
  logic [47:0] idIn = '0;
  logic        coilOpen, busy, frameDone;

  int checks = 0;
  int failures = 0;
  int stbGap = 0;
  int stbCnt = 0;
  int cycles = 0;
  bit finished = 0;
  string curTag = "R1";

  always #10 clk = ~clk;

  fsk_tag_wavegen uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .stopReq(stopReq),
    .sampleStb(sampleStb), .idIn(idIn), .coilOpen(coilOpen),
    .busy(busy), .frameDone(frameDone)
  );

  // ---------------- reference model ----------------
  bit    frameQ[$];
  string tagQ[$];
  bit    expBusy = 0, expCoil = 1, expDone = 0, emitted = 0;
  int    idx = 0, lastIdx = 0, sinceStart = 0, lastLen = 0;
  string coilTag = "R1";

  task automatic pushGroup(bit slow, string t);
    int per  = slow ? 10 : 8;
    int hi   = slow ? 3 : 2;
    int reps = slow ? 5 : 6;
    for (int r = 0; r < reps; r++)
      for (int p = 0; p < per; p++) begin
        frameQ.push_back(p < hi);
        tagQ.push_back(t);
      end
  endtask

  task automatic buildFrame(logic [43:0] id);
    bit sofSlow[8] = '{0, 0, 0, 1, 1, 1, 0, 1};
    frameQ.delete();
    tagQ.delete();
    for (int g = 0; g < 8; g++) pushGroup(sofSlow[g], "R3");
    for (int i = 43; i >= 0; i--) begin
      if (i % 4 == 3) pushGroup(1'b0, "R5");
      pushGroup(id[i], "R4");
      pushGroup(!id[i], "R4");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      expBusy = 0; expCoil = 1; expDone = 0; idx = 0; emitted = 0;
    end else begin
      expDone = 0;
      emitted = 0;
      if (!expBusy && startReq) begin
        if (idIn[47:44] == 4'h0) begin
          expBusy = 1;
          buildFrame(idIn[43:0]);
          idx = 0;
          sinceStart = 0;
        end
      end else if (expBusy && stopReq) begin
        expBusy = 0;
        expCoil = 1;
      end else if (expBusy && sampleStb) begin
        expCoil = frameQ[idx];
        coilTag = tagQ[idx];
        lastIdx = idx;
        emitted = 1;
        sinceStart++;
        if (idx == frameQ.size() - 1) begin
          expDone = 1;
          lastLen = sinceStart;
          sinceStart = 0;
          idx = 0;
        end else begin
          idx++;
        end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic check(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic checkInt(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  int opensFast = 0, opensSlow = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy, expBusy, curTag, "busy");
      check(frameDone, expDone, "R6", "frameDone");
      check(coilOpen, expCoil, emitted ? coilTag : curTag, "coilOpen");
      if (expDone) checkInt(lastLen, FRAME_LEN, "R6", "frame length in samples");
      if (emitted) begin
        // R2: count open samples of the first fast group and the first slow group
        if (lastIdx == 0) opensFast = 0;
        if (lastIdx < 48) opensFast += int'(coilOpen);
        if (lastIdx == 47) checkInt(opensFast, 12, "R2", "open samples in fast group");
        if (lastIdx == 144) opensSlow = 0;
        if (lastIdx >= 144 && lastIdx < 194) opensSlow += int'(coilOpen);
        if (lastIdx == 193) checkInt(opensSlow, 15, "R2", "open samples in slow group");
      end
    end
  end

  // strobe generator
  always @(negedge clk) begin
    stbCnt <= stbCnt + 1;
    sampleStb <= (stbGap != 0) && (stbCnt % (stbGap == 0 ? 1 : stbGap) == 0);
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart(logic [47:0] id);
    @(negedge clk);
    idIn = id;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish();
    end
  end

  initial begin
    curTag = "R1";
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(2);
    check(coilOpen, 1'b1, "R1", "coil after reset");
    check(busy, 1'b0, "R1", "busy after reset");
    check(frameDone, 1'b0, "R1", "frameDone after reset");

    // R8: strobes while idle have no effect
    curTag = "R8";
    stbGap = 1;
    waitCycles(20);
    check(coilOpen, 1'b1, "R8", "coil with idle strobes");

    // R7: identifier with a bit above bit 43 is refused
    curTag = "R7";
    pulseStart(48'h1000_0000_0001);
    waitCycles(5);
    check(busy, 1'b0, "R7", "busy after refused start");
    check(coilOpen, 1'b1, "R7", "coil after refused start");

    // R3/R4/R5/R6: continuous strobes, more than two frames
    curTag = "R6";
    pulseStart(48'h0ABC_1234_5678);
    waitCycles(2 * FRAME_LEN + 300);

    // R9: stop coinciding with a strobe
    curTag = "R9";
    pulseStop();
    check(busy, 1'b0, "R9", "busy after stop");
    check(coilOpen, 1'b1, "R9", "coil after stop");
    waitCycles(10);

    // R10: gapped strobes, start while busy is ignored
    stbGap = 3;
    curTag = "R4";
    pulseStart(48'h0E3D_5A96_0C71);
    waitCycles(700);
    curTag = "R10";
    pulseStart(48'h0FFF_FFFF_FFFF);
    check(busy, 1'b1, "R10", "busy after start while busy");
    waitCycles(3 * FRAME_LEN + 200);

    curTag = "R9";
    pulseStop();
    check(busy, 1'b0, "R9", "busy after second stop");
    check(coilOpen, 1'b1, "R9", "coil after second stop");
    stbGap = 0;
    waitCycles(5);
    finish();
  end

endmodule